// File: doc/BRIEF.md
# Tracking Auto-Adjust Controller

This controller drives the automatic tuning of a disc drive's tracking-error path. After a start pulse it first forces the tracking servo into its high-gain setting, so that the anti-shock path cannot disturb the measurement. It then searches the three-bit balance code and after that the three-bit gain code. Every candidate is sent as one command byte through a valid/ready write handshake. A serializer outside this block ships the byte to the analog front end.

The front end returns two signals. One is a comparator flag on `sense_in`, which reports "balance OK" after a balance write and "gain OK" after a gain write. The other is a track-crossing pulse train on `xing_in`. Each search begins at the power-on setting: balance code 111 (all balance switches open) and gain code 000 (all gain switches closed).

- The balance code counts down one step per failed try.
- A balance try is judged only when the crossing rate, measured as rising edges in a programmable window, reaches a programmable minimum. A slower rate repeats the window and leaves the code as it is.
- The gain code counts up one step per failed try. It is judged after a programmable settling delay.
- When eight candidates in either search all miss, the controller stops and raises a fail flag next to done.

Top module: `trk_autotune`

## Requirements
- R1: After reset `busy`, `done`, `fail` and `cmd_valid` are 0, `bal_code` is 3'b111 and `gain_code` is 3'b000.
- R2: A start pulse accepted while not busy makes the first command byte 8'h18: group nibble 4'h1, with bit 3 set (high gain) and bits 2:0 zero.
- R3: Balance commands are 8'h30 | code, meaning group nibble 4'h3, bit 3 = 0 and the code in bits 2:0. The first candidate is 7, and each failed try lowers the code by exactly 1.
- R4: A balance try is decided only at the end of a crossing window of `win_len` cycles whose rising-edge count on `xing_in` is at least `freq_min`. A window that falls short is repeated with the code unchanged and no command is written.
- R5: `sense_in` is sampled for a gain try in the cycle that ends `settle_len`+1 cycles after the gain command is accepted. It is never sampled earlier.
- R6: Balance OK (`sense_in` = 1 at a balance decision) ends the balance search. The gain search then writes 8'h38 | code (bit 3 = 1), starting at code 0 and raising the code by 1 per failed try.
- R7: Gain OK ends the run with `done` = 1, `busy` = 0, `fail` = 0, and both final codes held on the outputs.
- R8: Eight balance misses (codes 7 down to 0) or eight gain misses (codes 0 up to 7) end the run with `done` = 1 and `fail` = 1. A balance failure writes no gain command and leaves `gain_code` at 0.
- R9: `cmd_valid` is raised only while busy. Once raised, it stays high with an unchanged `cmd_byte` until `cmd_ready` is seen.
- R10: A start pulse while busy has no effect. A start pulse after completion clears `done` and `fail`, restores both codes to their initial values, and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a tuning run (pulse) |
| win_len | input | WIN_W | Crossing-count window length in cycles (0 treated as 1) |
| freq_min | input | CNT_W | Minimum rising edges per window for a balance decision |
| settle_len | input | SET_W | Settling cycles after a command is accepted |
| xing_in | input | 1 | Track-crossing pulse train |
| sense_in | input | 1 | Comparator OK flag from the front end |
| cmd_ready | input | 1 | Serializer accepts the command byte |
| cmd_valid | output | 1 | Command byte is offered |
| cmd_byte | output | 8 | Command byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (pass or fail) |
| fail | output | 1 | Run finished without an OK |
| bal_code | output | 3 | Current or final balance code |
| gain_code | output | 3 | Current or final gain code |

## Verification
The checker watches every cycle for several rules:
- the command handshake holds its byte until accepted;
- only the two legal command groups appear;
- the balance code moves only right after a crossing window that passed, and only down by one;
- the gain code moves only right after a settled gain decision, and only up by one;
- `fail` never appears without `done`.

Some behaviour only the bench's scenarios can show. These are the full byte order of a run, the exact final codes, the pass/fail outcome for every pair of balance and gain targets, and the refusal to step balance while crossings are absent. The bench's plant model keeps `sense_in` low until exactly `settle_len` cycles after acceptance, so sampling too early turns into extra writes.

// File: rtl/trk_tune_pkg.sv
package trk_tune_pkg;

  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] BAL_INIT  = 3'b111;
  localparam logic [CODE_W-1:0] GAIN_INIT = 3'b000;
  localparam logic [CODE_W-1:0] CODE_MAX  = 3'b111;
  localparam logic [CODE_W-1:0] CODE_MIN  = 3'b000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HG_WR,
    ST_BAL_WR,
    ST_BAL_SETTLE,
    ST_BAL_FREQ,
    ST_GAIN_WR,
    ST_GAIN_SETTLE,
    ST_END
  } tune_state_t;

  // servo-mode group with the high-gain bit set
  function automatic logic [7:0] hi_gain_cmd();
    return {4'h1, 1'b1, 3'b000};
  endfunction

  // adjust group, bit 3 clear: balance switches, low-pass comparator routed
  function automatic logic [7:0] bal_cmd(input logic [CODE_W-1:0] code);
    return {4'h3, 1'b0, code};
  endfunction

  // adjust group, bit 3 set: gain switches, high-pass comparator routed
  function automatic logic [7:0] gain_cmd(input logic [CODE_W-1:0] code);
    return {4'h3, 1'b1, code};
  endfunction

endpackage

// File: rtl/trk_tune_freqmeter.sv
module trk_tune_freqmeter #(
  parameter int WIN_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             xing,
  input  logic [WIN_W-1:0] win_len,
  input  logic [CNT_W-1:0] freq_min,
  output logic             win_end,
  output logic             freq_ok
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic             xing_q;
  logic [WIN_W-1:0] cyc;
  logic [CNT_W-1:0] edges, edges_next;
  logic [WIN_W-1:0] last_cyc;
  logic             rise;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic inc);
    return (inc && v != CNT_SAT) ? v + 1'b1 : v;
  endfunction

  assign rise       = xing & ~xing_q;
  assign edges_next = sat_inc(edges, rise);
  assign last_cyc   = (win_len == '0) ? '0 : win_len - 1'b1;
  assign win_end    = run && (cyc == last_cyc);
  assign freq_ok    = edges_next >= freq_min;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xing_q <= 1'b0;
      cyc    <= '0;
      edges  <= '0;
    end else begin
      xing_q <= xing;
      if (!run || win_end) begin
        cyc   <= '0;
        edges <= '0;
      end else begin
        cyc   <= cyc + 1'b1;
        edges <= edges_next;
      end
    end
  end
endmodule

// File: rtl/trk_tune_timer.sv
module trk_tune_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] len,
  output logic         expire
);
  logic [W-1:0] cnt;

  assign expire = run && (cnt == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expire) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/trk_autotune.sv
module trk_autotune
  import trk_tune_pkg::*;
#(
  parameter int WIN_W = 16,
  parameter int CNT_W = 8,
  parameter int SET_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WIN_W-1:0]  win_len,
  input  logic [CNT_W-1:0]  freq_min,
  input  logic [SET_W-1:0]  settle_len,
  input  logic              xing_in,
  input  logic              sense_in,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [7:0]        cmd_byte,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [CODE_W-1:0] bal_code,
  output logic [CODE_W-1:0] gain_code
);
  tune_state_t state;

  // named internal events, also used by the checker
  logic accept, settle_run, settle_done, freq_run, win_end, freq_ok;
  logic bal_decide, gain_decide;

  assign cmd_valid  = (state == ST_HG_WR) || (state == ST_BAL_WR) || (state == ST_GAIN_WR);
  assign accept     = cmd_valid && cmd_ready;
  assign busy       = (state != ST_IDLE) && (state != ST_END);
  assign settle_run = (state == ST_BAL_SETTLE) || (state == ST_GAIN_SETTLE);
  assign freq_run   = (state == ST_BAL_FREQ);
  assign bal_decide  = freq_run && win_end && freq_ok;
  assign gain_decide = (state == ST_GAIN_SETTLE) && settle_done;

  always_comb begin
    case (state)
      ST_HG_WR:   cmd_byte = hi_gain_cmd();
      ST_BAL_WR:  cmd_byte = bal_cmd(bal_code);
      ST_GAIN_WR: cmd_byte = gain_cmd(gain_code);
      default:    cmd_byte = 8'h00;
    endcase
  end

  trk_tune_freqmeter #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_freq (
    .clk(clk), .rst_n(rst_n), .run(freq_run), .xing(xing_in),
    .win_len(win_len), .freq_min(freq_min),
    .win_end(win_end), .freq_ok(freq_ok)
  );

  trk_tune_timer #(.W(SET_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .run(settle_run), .len(settle_len),
    .expire(settle_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bal_code  <= BAL_INIT;
      gain_code <= GAIN_INIT;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_END: if (start) begin
          state     <= ST_HG_WR;
          bal_code  <= BAL_INIT;
          gain_code <= GAIN_INIT;
          done      <= 1'b0;
          fail      <= 1'b0;
        end
        ST_HG_WR:      if (accept) state <= ST_BAL_WR;
        ST_BAL_WR:     if (accept) state <= ST_BAL_SETTLE;
        ST_BAL_SETTLE: if (settle_done) state <= ST_BAL_FREQ;
        ST_BAL_FREQ: if (bal_decide) begin
          if (sense_in) begin
            state <= ST_GAIN_WR;
          end else if (bal_code == CODE_MIN) begin
            state <= ST_END;
            done  <= 1'b1;
            fail  <= 1'b1;
          end else begin
            bal_code <= bal_code - 1'b1;
            state    <= ST_BAL_WR;
          end
        end
        ST_GAIN_WR:    if (accept) state <= ST_GAIN_SETTLE;
        ST_GAIN_SETTLE: if (gain_decide) begin
          if (sense_in) begin
            state <= ST_END;
            done  <= 1'b1;
          end else if (gain_code == CODE_MAX) begin
            state <= ST_END;
            done  <= 1'b1;
            fail  <= 1'b1;
          end else begin
            gain_code <= gain_code + 1'b1;
            state     <= ST_GAIN_WR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trk_autotune_chk.sv
module trk_autotune_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_byte,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic [2:0] bal_code,
  input logic [2:0] gain_code,
  input logic       win_end,
  input logic       freq_ok,
  input logic       gain_decide
);
  // R9: offered byte held until taken
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte));

  // R9: no command outside a run
  assert_valid_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  // R2, R3, R6: only the high-gain byte or adjust-group bytes appear
  assert_cmd_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_byte == 8'h18) || (cmd_byte[7:4] == 4'h3));

  // R4: balance code moves only after a passing window, and by -1
  assert_bal_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && (bal_code != $past(bal_code)) |->
      $past(win_end && freq_ok) && (bal_code == $past(bal_code) - 3'd1));

  // R6, R5: gain code moves only after a settled decision, and by +1
  assert_gain_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) && (gain_code != $past(gain_code)) |->
      $past(gain_decide) && (gain_code == $past(gain_code) + 3'd1));

  // R8: fail is reported together with done
  assert_fail_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  // R7: done and busy exclusive
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind trk_autotune trk_autotune_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_byte(cmd_byte), .busy(busy), .done(done), .fail(fail),
  .bal_code(bal_code), .gain_code(gain_code), .win_end(win_end),
  .freq_ok(freq_ok), .gain_decide(gain_decide)
);

// File: tb/sim_trk_autotune.sv
module sim_trk_autotune;
  localparam int WIN_W = 8;
  localparam int CNT_W = 6;
  localparam int SET_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [WIN_W-1:0] win_len = 8'd16;
  logic [CNT_W-1:0] freq_min = 6'd2;
  logic [SET_W-1:0] settle_len = 8'd3;
  logic xing_in = 1'b0;
  logic sense_in;
  logic cmd_ready = 1'b0;
  logic cmd_valid, busy, done, fail;
  logic [7:0] cmd_byte;
  logic [2:0] bal_code, gain_code;

  always #4 clk = ~clk;

  trk_autotune #(.WIN_W(WIN_W), .CNT_W(CNT_W), .SET_W(SET_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .win_len(win_len),
    .freq_min(freq_min), .settle_len(settle_len), .xing_in(xing_in),
    .sense_in(sense_in), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .busy(busy), .done(done), .fail(fail),
    .bal_code(bal_code), .gain_code(gain_code)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int bt = 8, gt = 8;          // plant targets, 8 = never OK
  bit xing_en = 1'b1;
  int base_n = 0;
  int wr_n = 0, seq_err = 0, hold_err = 0;
  logic [7:0] last_cmd = 8'h00;
  logic [7:0] age = 8'hff;
  logic pv = 1'b0, pr = 1'b0;
  logic [7:0] pb = 8'h00;

  // expected k-th byte of a run with targets b, g
  function automatic logic [7:0] exp_byte(int k, int b, int g);
    int nb;
    nb = (b == 8) ? 8 : 8 - b;
    if (k == 0) return 8'h18;
    if (k <= nb) return 8'h30 | 8'(7 - (k - 1));
    return 8'h38 | 8'(k - 1 - nb);
  endfunction

  function automatic int exp_count(int b, int g);
    if (b == 8) return 9;
    return 1 + (8 - b) + ((g == 8) ? 8 : g + 1);
  endfunction

  // plant: comparator follows the last adjust write after settle_len cycles
  assign sense_in = (age >= settle_len) &&
    (((last_cmd[7:3] == 5'b00110) && (int'(last_cmd[2:0]) == bt)) ||
     ((last_cmd[7:3] == 5'b00111) && (int'(last_cmd[2:0]) == gt)));

  always @(posedge clk) begin
    if (pv && !pr && (!cmd_valid || cmd_byte != pb)) hold_err <= hold_err + 1;
    pv <= cmd_valid; pr <= cmd_ready; pb <= cmd_byte;
    if (cmd_valid && cmd_ready) begin
      if (cmd_byte != exp_byte(wr_n - base_n, bt, gt)) seq_err <= seq_err + 1;
      last_cmd <= cmd_byte;
      age      <= 8'd0;
      wr_n     <= wr_n + 1;
    end else if (age != 8'hff) begin
      age <= age + 8'd1;
    end
  end

  // ready pattern and crossing train
  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c++;
      cmd_ready = (c % 3) != 0;
      if (xing_en && (c % 2 == 0)) xing_in = ~xing_in;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 6000) begin @(negedge clk); t++; end
    chk(t < 6000, "R7 run completes", t, 6000);
  endtask

  task automatic run_case(int b, int g);
    int e0;
    @(negedge clk);
    bt = b; gt = g; e0 = seq_err; base_n = wr_n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(done == 1'b1 && busy == 1'b0, "R7 done and idle", {done, busy}, 2);
    chk(fail == (b == 8 || g == 8), "R8 fail flag", fail, (b == 8 || g == 8));
    chk(int'(bal_code) == ((b == 8) ? 0 : b), "R3 final balance code", bal_code, (b == 8) ? 0 : b);
    chk(int'(gain_code) == ((b == 8) ? 0 : ((g == 8) ? 7 : g)), "R6 R5 final gain code",
        gain_code, (b == 8) ? 0 : ((g == 8) ? 7 : g));
    chk(wr_n - base_n == exp_count(b, g), "R3 R6 write count", wr_n - base_n, exp_count(b, g));
    chk(seq_err == e0, "R2 R3 R6 byte order", seq_err - e0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !fail && !cmd_valid, "R1 idle flags", {busy, done, fail, cmd_valid}, 0);
    chk(bal_code == 3'b111, "R1 balance init", bal_code, 7);
    chk(gain_code == 3'b000, "R1 gain init", gain_code, 0);

    // R4: no crossings, balance must stall at its first candidate
    xing_en = 1'b0;
    bt = 3; gt = 2; base_n = wr_n;
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    chk(wr_n - base_n == 2, "R4 writes while stalled", wr_n - base_n, 2);
    chk(bal_code == 3'b111 && busy, "R4 balance code held", bal_code, 7);
    // R10: start while busy ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (50) @(negedge clk);
    chk(wr_n - base_n == 2, "R10 start ignored while busy", wr_n - base_n, 2);
    xing_en = 1'b1;
    wait_done();
    chk(bal_code == 3'd3 && gain_code == 3'd2 && !fail, "R4 R10 resumed run result",
        {bal_code, gain_code}, {3'd3, 3'd2});
    chk(wr_n - base_n == exp_count(3, 2), "R10 resumed write count", wr_n - base_n, exp_count(3, 2));
    chk(seq_err == 0, "R2 R10 byte order after stall", seq_err, 0);

    // sweep every balance and gain target, including never-OK
    for (int b = 0; b <= 8; b++)
      for (int g = 0; g <= 8; g++)
        run_case(b, g);

    // R5 with a longer settle
    settle_len = 8'd7;
    run_case(5, 4);
    run_case(0, 8);
    settle_len = 8'd0;
    run_case(6, 1);

    chk(hold_err == 0, "R9 handshake hold", hold_err, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule